// File: doc/BRIEF.md
# VLIW Packet Issue Sequencer

This block walks through one very-long-instruction-word packet. A start strobe begins the packet at the current program counter. The sequencer fetches 32-bit words one at a time from an instruction memory port and hands each word to an execute stage, with flags that mark the first and the last word of the packet. The execute stage returns the address of the next word. While each word executes, the sequencer also captures the functional-unit slot that the allocator gave to it.

A packet ends in one of two ways. Either a word with its top bit set has executed, or the parameterised slot limit has been reached. Whichever comes first decides. When the packet ends, the sequencer pulses a strobe that checks for interrupts and commits the deferred writes. It then adds the number of issued words to a running count.

The block also has two side duties:
- Before each word executes, it asks for register zero to be cleared.
- It remembers the last media-unit slot used in the packet. At packet start this record is set to "none".

Top module: `vliw_issue_seq`

## Requirements
- R1: A word whose bit 31 is 1 is the last of its packet. `exec_last` is high for it, and after it executes `irq_check` pulses in the next cycle.
- R2: A packet never issues more than MAX_SLOTS words (default 4). The word at index MAX_SLOTS-1 is marked last even when its bit 31 is 0.
- R3: `exec_first` is 1 for the first word of each packet and 0 for every later word.
- R4: `gr0_clr` pulses once per word, in the grant cycle of that word's fetch. This is the cycle just before that word appears on `exec_valid`.
- R5: When `start` is accepted in the idle state, `queue_init` is high in that same cycle. The media-slot record (`media_vld` = 0) and `err_mask` are cleared for the new packet.
- R6: A slot code in the range 4 to 7 (MEDIA_BASE to MEDIA_BASE+3) is a media slot. The record holds the last media slot taken by a word in the packet. Codes 0 to 3 leave the record unchanged.
- R7: After each word executes, the program counter takes the value on `exec_next_pc`, and the next fetch uses that address.
- R8: In the cycle after `irq_check`, `insn_count` has grown by the number of words issued in the packet. The count is 0 after reset.
- R9: While `imem_req` is high and `imem_gnt` is low, the sequencer holds its fetch. The address stays stable, no word is issued and `gr0_clr` stays low.
- R10: A word executed with `slot_err` high sets bit k of `err_mask`, where k is the word's index in the packet. The packet carries on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet at the current PC (accepted when idle) |
| busy | output | 1 | Packet in progress |
| pc_out | output | AW | Current program counter |
| queue_init | output | 1 | Deferred-write queue initialise strobe |
| imem_req | output | 1 | Instruction fetch request |
| imem_addr | output | AW | Fetch address |
| imem_gnt | input | 1 | Fetch granted; data valid this cycle |
| imem_data | input | 32 | Fetched instruction word |
| gr0_clr | output | 1 | Clear register zero before the next word executes |
| exec_valid | output | 1 | Word presented to execute |
| exec_word | output | 32 | Word to execute |
| exec_first | output | 1 | First word of the packet |
| exec_last | output | 1 | Last word of the packet |
| exec_ready | input | 1 | Execute accepts the word this cycle |
| exec_next_pc | input | AW | Next PC returned by execute |
| slot_code | input | SLOTW | Unit slot assigned to the executing word |
| slot_err | input | 1 | Slot assignment failed for the executing word |
| media_vld | output | 1 | A media slot was used in this packet |
| media_slot | output | SLOTW | Last media slot used |
| err_mask | output | MAX_SLOTS | Per-index slot-error flags for the packet |
| irq_check | output | 1 | Interrupt check and write-back commit strobe |
| insn_count | output | CW | Running count of issued words |

## Verification
The bench sweeps four things:
- the position of the stop bit, from word 0 to word 3 and also no stop bit at all;
- a fetch-grant delay of zero to two cycles;
- sequential flow versus a jump returned by execute;
- slot and error patterns derived from the loop indices.

The stop-bit positions separate an early end through bit 31 from an end at the slot limit. The grant delays show whether the fetch really stalls and whether the register-zero strobe lines up with the grant. The jumps separate taking the returned PC from incrementing it on its own, and the slot patterns show which media slot is the last one recorded.

// File: rtl/vliw_issue_seq.sv
module vliw_issue_seq #(
  parameter int          AW         = 32,
  parameter int          MAX_SLOTS  = 4,
  parameter int          SLOTW      = 3,
  parameter int          MEDIA_BASE = 4,
  parameter int          CW         = 32,
  parameter logic [31:0] RESET_PC   = 32'h0000_1000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 busy,
  output logic [AW-1:0]        pc_out,
  output logic                 queue_init,
  output logic                 imem_req,
  output logic [AW-1:0]        imem_addr,
  input  logic                 imem_gnt,
  input  logic [31:0]          imem_data,
  output logic                 gr0_clr,
  output logic                 exec_valid,
  output logic [31:0]          exec_word,
  output logic                 exec_first,
  output logic                 exec_last,
  input  logic                 exec_ready,
  input  logic [AW-1:0]        exec_next_pc,
  input  logic [SLOTW-1:0]     slot_code,
  input  logic                 slot_err,
  output logic                 media_vld,
  output logic [SLOTW-1:0]     media_slot,
  output logic [MAX_SLOTS-1:0] err_mask,
  output logic                 irq_check,
  output logic [CW-1:0]        insn_count
);
  localparam int IW = $clog2(MAX_SLOTS + 1);
  localparam logic [SLOTW:0] MLO = (SLOTW+1)'(MEDIA_BASE);
  localparam logic [SLOTW:0] MHI = (SLOTW+1)'(MEDIA_BASE + 3);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EXEC, S_DONE} st_t;

  st_t          st;
  logic [AW-1:0] pc;
  logic [31:0]   word;
  logic [IW-1:0] idx;

  wire handshake = (st == S_EXEC) && exec_ready;
  wire is_media  = ({1'b0, slot_code} >= MLO) && ({1'b0, slot_code} <= MHI);

  assign busy       = (st != S_IDLE);
  assign pc_out     = pc;
  assign queue_init = (st == S_IDLE) && start;
  assign imem_req   = (st == S_FETCH);
  assign imem_addr  = pc;
  assign gr0_clr    = (st == S_FETCH) && imem_gnt;
  assign exec_valid = (st == S_EXEC);
  assign exec_word  = word;
  assign exec_first = (idx == '0);
  assign exec_last  = word[31] || (idx == IW'(MAX_SLOTS - 1));
  assign irq_check  = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pc         <= AW'(RESET_PC);
      word       <= '0;
      idx        <= '0;
      media_vld  <= 1'b0;
      media_slot <= '0;
      err_mask   <= '0;
      insn_count <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st        <= S_FETCH;
          idx       <= '0;
          media_vld <= 1'b0;
          err_mask  <= '0;
        end
        S_FETCH: if (imem_gnt) begin
          word <= imem_data;
          st   <= S_EXEC;
        end
        S_EXEC: if (exec_ready) begin
          pc  <= exec_next_pc;
          idx <= idx + 1'b1;
          if (is_media) begin
            media_vld  <= 1'b1;
            media_slot <= slot_code;
          end
          if (slot_err)
            err_mask <= err_mask | (MAX_SLOTS'(1) << idx);
          st <= exec_last ? S_DONE : S_FETCH;
        end
        S_DONE: begin
          insn_count <= insn_count + CW'(idx);
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_stop_bit_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (handshake && word[31]) |=> irq_check);

  a_r2_slot_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (handshake && idx == IW'(MAX_SLOTS - 1)) |=> irq_check);

  a_r3_first_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && !$past(exec_valid) && $past(gr0_clr) && !exec_first) |-> $past(idx) != '0);

  a_r4_clear_before_exec: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exec_valid) |-> $past(gr0_clr));

  a_r5_init_clears_media: assert property (@(posedge clk) disable iff (!rst_n)
    queue_init |=> (!media_vld && err_mask == '0));

  a_r6_media_record: assert property (@(posedge clk) disable iff (!rst_n)
    (handshake && is_media) |=> (media_vld && media_slot == $past(slot_code)));

  a_r7_pc_update: assert property (@(posedge clk) disable iff (!rst_n)
    handshake |=> pc_out == $past(exec_next_pc));

  a_r9_fetch_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_req && !imem_gnt) |=> (imem_req && $stable(imem_addr) && !exec_valid));
endmodule

// File: tb/vliw_issue_seq_tb.sv
module vliw_issue_seq_tb;
  localparam int MAXS = 4;

  logic        clk = 0, rst_n = 0, start = 0;
  logic        busy, queue_init, imem_req, imem_gnt = 0, gr0_clr;
  logic [31:0] pc_out, imem_addr, imem_data, exec_word, exec_next_pc = 0;
  logic        exec_valid, exec_first, exec_last, exec_ready = 1;
  logic [2:0]  slot_code = 0, media_slot;
  logic        slot_err = 0, media_vld, irq_check;
  logic [3:0]  err_mask;
  logic [31:0] insn_count;
  logic [31:0] stop_addr = 32'hFFFF_FFF0;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [31:0] exp_pc = 32'h0000_1000;
  logic [31:0] exp_cnt = 0;

  always #4 clk = ~clk;

  assign imem_data = {imem_addr == stop_addr, imem_addr[30:0]};

  vliw_issue_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .pc_out(pc_out),
    .queue_init(queue_init), .imem_req(imem_req), .imem_addr(imem_addr),
    .imem_gnt(imem_gnt), .imem_data(imem_data), .gr0_clr(gr0_clr),
    .exec_valid(exec_valid), .exec_word(exec_word), .exec_first(exec_first),
    .exec_last(exec_last), .exec_ready(exec_ready), .exec_next_pc(exec_next_pc),
    .slot_code(slot_code), .slot_err(slot_err), .media_vld(media_vld),
    .media_slot(media_slot), .err_mask(err_mask), .irq_check(irq_check),
    .insn_count(insn_count)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_packet(input int stop_at, input int gap, input bit jump);
    logic [31:0] ad [0:MAXS];
    logic [2:0]  sp [0:MAXS-1];
    logic        ep [0:MAXS-1];
    int n;
    bit e_mv;
    logic [2:0] e_ms;
    logic [3:0] e_err;
    n = (stop_at < MAXS) ? stop_at + 1 : MAXS;
    ad[0] = exp_pc;
    for (int k = 0; k < MAXS; k++) begin
      ad[k+1] = (jump && k == 1) ? ad[k] + 32'h100 : ad[k] + 32'd4;
      sp[k]   = 3'((k * 3 + stop_at + gap) % 8);
      ep[k]   = ((k + gap) % 3) == 0;
    end
    stop_addr = (stop_at < MAXS) ? ad[stop_at] : 32'hFFFF_FFF0;
    e_mv = 0; e_ms = 0; e_err = 0;
    for (int k = 0; k < n; k++) begin
      if (sp[k] >= 3'd4) begin e_mv = 1; e_ms = sp[k]; end
      if (ep[k]) e_err[k] = 1'b1;
    end

    start = 1;
    #1 chk(queue_init == 1'b1, "R5 queue_init on start", 32'(queue_init), 1);
    @(negedge clk);
    start = 0;
    chk(media_vld == 1'b0, "R5 media cleared", 32'(media_vld), 0);
    for (int k = 0; k < n; k++) begin
      for (int g = 0; g < gap; g++) begin
        chk(imem_req && imem_addr == ad[k], "R9 stalled fetch address", imem_addr, ad[k]);
        chk(gr0_clr == 1'b0 && exec_valid == 1'b0, "R9 no issue while stalled", 32'({gr0_clr, exec_valid}), 0);
        @(negedge clk);
      end
      chk(imem_req && imem_addr == ad[k], "R7 fetch address", imem_addr, ad[k]);
      imem_gnt = 1;
      slot_code = sp[k];
      slot_err = ep[k];
      exec_next_pc = ad[k+1];
      #1 chk(gr0_clr == 1'b1, "R4 gr0 clear at grant", 32'(gr0_clr), 1);
      @(negedge clk);
      imem_gnt = 0;
      chk(exec_valid == 1'b1, "R4 word issued after clear", 32'(exec_valid), 1);
      chk(exec_word == {ad[k] == stop_addr, ad[k][30:0]}, "R7 word", exec_word, {ad[k] == stop_addr, ad[k][30:0]});
      chk(exec_first == (k == 0), "R3 first flag", 32'(exec_first), 32'(k == 0));
      chk(exec_last == (k == n - 1), (stop_at < MAXS) ? "R1 last flag" : "R2 last flag at limit",
          32'(exec_last), 32'(k == n - 1));
      @(negedge clk);
    end
    chk(irq_check == 1'b1, (stop_at < MAXS) ? "R1 irq_check after stop" : "R2 irq_check at limit", 32'(irq_check), 1);
    @(negedge clk);
    exp_cnt += 32'(n);
    exp_pc = ad[n];
    chk(insn_count == exp_cnt, "R8 count", insn_count, exp_cnt);
    chk(busy == 1'b0 && irq_check == 1'b0, "R8 idle after packet", 32'({busy, irq_check}), 0);
    chk(pc_out == exp_pc, "R7 pc after packet", pc_out, exp_pc);
    chk(media_vld == e_mv && (!e_mv || media_slot == e_ms), "R6 media record",
        32'({media_vld, media_slot}), 32'({e_mv, e_ms}));
    chk(err_mask == e_err, "R10 error mask", 32'(err_mask), 32'(e_err));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(insn_count == 0, "R8 count reset", insn_count, 0);
    chk(busy == 0 && imem_req == 0 && media_vld == 0, "R5 idle reset state", 32'({busy, imem_req, media_vld}), 0);
    chk(pc_out == 32'h1000, "R7 reset pc", pc_out, 32'h1000);
    for (int j = 0; j < 2; j++)
      for (int s = 0; s <= MAXS; s++)
        for (int g = 0; g < 3; g++) begin
          run_packet(s, g, j[0]);
          @(negedge clk);
        end
    finished = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !finished; c++) @(negedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule